// File: doc/BRIEF.md
# Clock Prescaler Mode Controller

This block controls the bypass path of a clock generation unit. A reference clock is taken either from an external oscillator or from an internal clock source. It is divided by a programmable integer ratio, and the divided result is delivered as a single-cycle clock-enable pulse. The whole design therefore runs in one clock domain, and the analog loop, the oscillator and its watchdog are modelled as plain inputs. Each reference clock appears as a one-cycle tick on its input.

Software requests prescaler mode through a configuration write. The mode only takes effect when the oscillator-valid indication agrees. A status output reports the mode that is actually in effect. The divider ratio is changed through a ready handshake: a new ratio waits for the end of the current output period, so no shortened period is ever produced. A write made while a change is still pending is rejected and flagged. When the disconnect option is enabled, a loss-of-lock indication stops the reference from being forwarded to the oscillator-loop input.

Top module: `clk_prescale_ctrl`

## Requirements
- R1: After reset, `byp_active` is 0, `div_ready` is 1, `div_wr_err` is 0 and `sys_clk_en` is 0. The ratio field is 0 (division by 1), and the request, source and disconnect settings are all 0.
- R2: `byp_active` rises at the first clock edge at which the registered request is 1, `byp_active` is 0 and `osc_valid` is 1. While `osc_valid` is 0, a pending request does not set it.
- R3: `byp_active` falls at the clock edge after a configuration write that clears the request. `sys_clk_en` is 0 whenever `byp_active` is 0.
- R4: With a ratio field value N, `sys_clk_en` is high for one cycle in the cycle after every (N+1)th tick of the selected reference. N = 0 passes every tick through.
- R5: `cfg_src_int` = 0 selects `osc_ext_tick` and 1 selects `int_src_tick`. Ticks on the source that is not selected have no effect on the divider.
- R6: A ratio write accepted while `div_ready` is 1 drops `div_ready` at that edge. The new ratio takes effect at the next output-period boundary, and `div_ready` rises at that same edge.
- R7: A ratio write while `div_ready` is 0 is discarded and sets `div_wr_err`, which stays set until reset.
- R8: `vco_ref_tick` equals the selected reference tick, except that it is forced to 0 whenever, at the previous clock edge, the disconnect setting was 1 and `lock_lost` was 1.
- R9: Once `byp_active` is 1, a drop of `osc_valid` does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Strobe that loads the three configuration bits |
| cfg_mode_req | input | 1 | Prescaler mode request |
| cfg_src_int | input | 1 | Reference select: 0 external oscillator, 1 internal source |
| cfg_disc_en | input | 1 | Allow disconnection of the reference on loss of lock |
| div_wr | input | 1 | Ratio write strobe |
| div_val | input | DIV_W | Ratio field, divides by value+1 |
| osc_ext_tick | input | 1 | External oscillator tick |
| int_src_tick | input | 1 | Internal source tick |
| osc_valid | input | 1 | Oscillator-valid indication |
| lock_lost | input | 1 | Loss-of-lock indication |
| sys_clk_en | output | 1 | Divided clock-enable pulse |
| vco_ref_tick | output | 1 | Reference forwarded to the oscillator-loop input |
| byp_active | output | 1 | Prescaler mode in effect |
| div_ready | output | 1 | Ratio may be written |
| div_wr_err | output | 1 | Sticky rejected-write flag |

## Verification
The hardest case to reach from the ports is a second ratio write that lands while the first is still waiting for a period boundary. The bench first loads a large ratio and lets it take effect. It then writes a small ratio and follows it at once with a conflicting one, before any reference tick arrives. It then steps reference ticks one at a time, which shows that the old period completes in full, that the first value, not the second, is applied at the boundary, and that the error flag stays set.

// File: rtl/clk_prescale_pkg.sv
// Shared definitions for the prescaler mode controller.
// Assumes: nothing beyond IEEE 1800-2017.
package clk_prescale_pkg;

    // Registered configuration word written through cfg_wr.
    typedef struct packed {
        logic mode_req;
        logic src_int;
        logic disc_en;
    } pscl_cfg_t;

    localparam pscl_cfg_t PSCL_CFG_RST = '{mode_req: 1'b0, src_int: 1'b0, disc_en: 1'b0};

endpackage

// File: rtl/pscl_ref_select.sv
// Reference selection and loop-input gating.
// Picks the external or internal tick as the divider reference and forwards
// it to the oscillator-loop input unless the loss-of-lock disconnect holds.
// Assumes: ticks are single-cycle pulses synchronous to clk.
module pscl_ref_select (
    input  logic clk,
    input  logic rst_n,
    input  logic src_int,
    input  logic disc_en,
    input  logic lock_lost,
    input  logic ext_tick,
    input  logic int_tick,
    output logic ref_tick,
    output logic loop_tick
);

    logic disc_q;

    // Purpose: choose the reference tick from the configured source.
    always_comb begin
        ref_tick = src_int ? int_tick : ext_tick;
    end

    // Purpose: register the disconnect condition for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disc_q <= 1'b0;
        end else begin
            disc_q <= disc_en & lock_lost;
        end
    end

    // Purpose: block the forwarded reference while disconnected.
    always_comb begin
        loop_tick = ref_tick & ~disc_q;
    end

endmodule

// File: rtl/pscl_mode_ctrl.sv
// Prescaler mode entry and exit control.
// Enters the mode when the request is set, the mode is not yet active and the
// oscillator is valid; leaves it once the request is cleared.
// Assumes: mode_req comes from a register in the same clock domain.
module pscl_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_req,
    input  logic osc_valid,
    output logic mode_act
);

    logic enter_ok;

    // Purpose: evaluate the entry condition from the current status.
    always_comb begin
        enter_ok = mode_req & ~mode_act & osc_valid;
    end

    // Purpose: hold the mode status that is actually in effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_act <= 1'b0;
        end else if (!mode_req) begin
            mode_act <= 1'b0;
        end else if (enter_ok) begin
            mode_act <= 1'b1;
        end
    end

endmodule

// File: rtl/pscl_k1_divider.sv
// Programmable integer divider with glitch-free ratio update.
// Counts reference ticks and emits a one-cycle pulse every (ratio+1) ticks.
// A written ratio is held pending and adopted at the next period boundary.
// Assumes: a write and a boundary in the same cycle are legal but rare.
module pscl_k1_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             wr_req,
    input  logic [DIV_W-1:0] wr_val,
    output logic             div_tick,
    output logic             ready,
    output logic             wr_err
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cur_q;
    logic [DIV_W-1:0] pend_val_q;
    logic             pend_q;
    logic             at_end;

    // Purpose: detect the last reference tick of the current period.
    always_comb begin
        at_end = ref_tick && (cnt_q == cur_q);
    end

    // Purpose: advance the period counter on each reference tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else if (ref_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: produce the registered output pulse at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_tick <= 1'b0;
        end else begin
            div_tick <= at_end;
        end
    end

    // Purpose: capture an accepted write into the pending slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_val_q <= '0;
        end else if (wr_req && !pend_q) begin
            pend_val_q <= wr_val;
        end
    end

    // Purpose: track whether a written ratio awaits its boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wr_req && !pend_q) begin
            pend_q <= 1'b1;
        end else if (at_end) begin
            pend_q <= 1'b0;
        end
    end

    // Purpose: adopt the pending ratio at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (at_end && pend_q) begin
            cur_q <= pend_val_q;
        end
    end

    // Purpose: latch a rejected write until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else if (wr_req && pend_q) begin
            wr_err <= 1'b1;
        end
    end

    // Purpose: report that a new ratio may be written.
    always_comb begin
        ready = ~pend_q;
    end

endmodule

// File: rtl/clk_prescale_ctrl.sv
// Top of the prescaler mode controller.
// Holds the configuration register and ties together source selection,
// mode control and the divider; the divided clock leaves as an enable.
// Assumes: single clock domain, synchronous active-low reset.
module clk_prescale_ctrl
    import clk_prescale_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_mode_req,
    input  logic             cfg_src_int,
    input  logic             cfg_disc_en,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             osc_ext_tick,
    input  logic             int_src_tick,
    input  logic             osc_valid,
    input  logic             lock_lost,
    output logic             sys_clk_en,
    output logic             vco_ref_tick,
    output logic             byp_active,
    output logic             div_ready,
    output logic             div_wr_err
);

    pscl_cfg_t cfg_q;
    logic      ref_tick;
    logic      div_tick;
    logic      cfg_disc_q;
    logic      mode_req_q;

    // Purpose: hold the configuration bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= PSCL_CFG_RST;
        end else if (cfg_wr) begin
            cfg_q <= '{mode_req: cfg_mode_req, src_int: cfg_src_int, disc_en: cfg_disc_en};
        end
    end

    // Purpose: expose individual configuration bits for the checker.
    always_comb begin
        cfg_disc_q = cfg_q.disc_en;
        mode_req_q = cfg_q.mode_req;
    end

    pscl_ref_select u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_int   (cfg_q.src_int),
        .disc_en   (cfg_q.disc_en),
        .lock_lost (lock_lost),
        .ext_tick  (osc_ext_tick),
        .int_tick  (int_src_tick),
        .ref_tick  (ref_tick),
        .loop_tick (vco_ref_tick)
    );

    pscl_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_req  (cfg_q.mode_req),
        .osc_valid (osc_valid),
        .mode_act  (byp_active)
    );

    pscl_k1_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .wr_req   (div_wr),
        .wr_val   (div_val),
        .div_tick (div_tick),
        .ready    (div_ready),
        .wr_err   (div_wr_err)
    );

    // Purpose: pass the divided pulse only while the mode is in effect.
    always_comb begin
        sys_clk_en = div_tick & byp_active;
    end

endmodule

// File: rtl/clk_prescale_ctrl_chk.sv
// Property checker for the prescaler mode controller, bound to its top.
// Assumes: connected through the bind below to the top's ports and state.
module clk_prescale_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic osc_valid,
    input logic byp_active,
    input logic mode_req_q,
    input logic div_wr,
    input logic div_ready,
    input logic div_wr_err,
    input logic div_tick,
    input logic cfg_disc_q,
    input logic lock_lost,
    input logic vco_ref_tick
);

    // R2: the mode can only start after a valid oscillator was seen
    a_r2_entry_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byp_active) |-> $past(osc_valid));

    // R3: leaving the mode follows a cleared request
    a_r3_exit_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(byp_active) |-> $past(!mode_req_q));

    // R6: ready only falls on an accepted write
    a_r6_ready_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_ready) |-> $past(div_wr));

    // R6: ready only returns together with a period boundary
    a_r6_ready_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_ready) |-> div_tick);

    // R7: the rejected-write flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr_err |=> div_wr_err);

    // R8: a disconnect blocks the forwarded reference
    a_r8_disconnect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_disc_q && lock_lost) |-> !vco_ref_tick);

endmodule

bind clk_prescale_ctrl clk_prescale_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_valid    (osc_valid),
    .byp_active   (byp_active),
    .mode_req_q   (mode_req_q),
    .div_wr       (div_wr),
    .div_ready    (div_ready),
    .div_wr_err   (div_wr_err),
    .div_tick     (div_tick),
    .cfg_disc_q   (cfg_disc_q),
    .lock_lost    (lock_lost),
    .vco_ref_tick (vco_ref_tick)
);

// File: tb/clk_prescale_ctrl_tb_top.sv
// Directed bench for the prescaler mode controller.
module clk_prescale_ctrl_tb_top;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_mode_req = 1'b0;
    logic             cfg_src_int = 1'b0;
    logic             cfg_disc_en = 1'b0;
    logic             div_wr = 1'b0;
    logic [DIV_W-1:0] div_val = '0;
    logic             osc_ext_tick = 1'b0;
    logic             int_src_tick = 1'b0;
    logic             osc_valid = 1'b0;
    logic             lock_lost = 1'b0;
    logic             sys_clk_en;
    logic             vco_ref_tick;
    logic             byp_active;
    logic             div_ready;
    logic             div_wr_err;

    int checks = 0;
    int errors = 0;

    // Expected-state model built from the requirements
    int m_cnt = 0;
    int m_div = 0;
    int m_pv = 0;
    bit m_pend = 0;
    bit m_err = 0;
    bit m_byp = 0;
    bit m_src = 0;
    bit m_block = 0;
    int pulses = 0;

    always #2 clk = ~clk;

    clk_prescale_ctrl #(.DIV_W(DIV_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_mode_req (cfg_mode_req),
        .cfg_src_int  (cfg_src_int),
        .cfg_disc_en  (cfg_disc_en),
        .div_wr       (div_wr),
        .div_val      (div_val),
        .osc_ext_tick (osc_ext_tick),
        .int_src_tick (int_src_tick),
        .osc_valid    (osc_valid),
        .lock_lost    (lock_lost),
        .sys_clk_en   (sys_clk_en),
        .vco_ref_tick (vco_ref_tick),
        .byp_active   (byp_active),
        .div_ready    (div_ready),
        .div_wr_err   (div_wr_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance n idle cycles; no divided pulse may appear
    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            #1;
            chk(req, "sys_clk_en idle", sys_clk_en, 0);
        end
    endtask

    // One reference tick on the chosen input, checked against the model
    task automatic ref_tick(input bit use_int, input string req);
        bit sel;
        bit exp_en;
        @(negedge clk);
        osc_ext_tick = !use_int;
        int_src_tick = use_int;
        sel = (use_int == m_src);
        #1;
        chk(req, "vco_ref_tick", vco_ref_tick, (sel && !m_block) ? 1 : 0);
        @(posedge clk);
        @(negedge clk);
        osc_ext_tick = 1'b0;
        int_src_tick = 1'b0;
        exp_en = 1'b0;
        if (sel) begin
            if (m_cnt == m_div) begin
                exp_en = m_byp;
                m_cnt = 0;
                if (m_pend) begin
                    m_div = m_pv;
                    m_pend = 0;
                end
            end else begin
                m_cnt++;
            end
        end
        #1;
        if (sys_clk_en) pulses++;
        chk(req, "sys_clk_en", sys_clk_en, exp_en);
        chk("R6", "div_ready", div_ready, m_pend ? 0 : 1);
    endtask

    task automatic write_div(input int v);
        @(negedge clk);
        div_wr = 1'b1;
        div_val = DIV_W'(v);
        @(posedge clk);
        @(negedge clk);
        div_wr = 1'b0;
        if (m_pend) m_err = 1;
        else begin
            m_pend = 1;
            m_pv = v;
        end
        #1;
    endtask

    task automatic write_cfg(input bit req, input bit src, input bit disc);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_mode_req = req;
        cfg_src_int = src;
        cfg_disc_en = disc;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        m_src = src;
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "byp_active", byp_active, 0);
        chk("R1", "div_ready", div_ready, 1);
        chk("R1", "div_wr_err", div_wr_err, 0);
        chk("R1", "sys_clk_en", sys_clk_en, 0);
    endtask

    task automatic t_entry();
        osc_valid = 1'b0;
        write_cfg(1, 0, 0);
        idle(3, "R2");
        chk("R2", "byp_active blocked by osc_valid", byp_active, 0);
        ref_tick(0, "R3");
        osc_valid = 1'b1;
        #1;
        chk("R2", "byp_active before edge", byp_active, 0);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R2", "byp_active one edge after", byp_active, 1);
        m_byp = 1;
        osc_valid = 1'b0;
        idle(2, "R9");
        chk("R9", "byp_active after osc drop", byp_active, 1);
        osc_valid = 1'b1;
    endtask

    task automatic t_divide();
        for (int i = 0; i < 3; i++) ref_tick(0, "R4");
        write_div(3);
        chk("R6", "div_ready after write", div_ready, 0);
        ref_tick(0, "R6");
        chk("R6", "div_ready at boundary", div_ready, 1);
        pulses = 0;
        for (int i = 0; i < 8; i++) ref_tick(0, "R4");
        chk("R4", "pulses in 8 ticks at ratio 4", pulses, 2);
    endtask

    task automatic t_reject();
        write_div(1);
        write_div(5);
        chk("R7", "div_wr_err", div_wr_err, 1);
        chk("R7", "div_ready still low", div_ready, 0);
        pulses = 0;
        for (int i = 0; i < 4; i++) ref_tick(0, "R6");
        chk("R6", "old period completes", pulses, 1);
        pulses = 0;
        for (int i = 0; i < 6; i++) ref_tick(0, "R7");
        chk("R7", "first value applied, second discarded", pulses, 3);
        chk("R7", "div_wr_err sticky", div_wr_err, 1);
    endtask

    task automatic t_source();
        write_cfg(1, 1, 0);
        pulses = 0;
        for (int i = 0; i < 4; i++) ref_tick(0, "R5");
        chk("R5", "external ticks ignored", pulses, 0);
        for (int i = 0; i < 4; i++) ref_tick(1, "R5");
        chk("R5", "internal ticks divided", pulses, 2);
    endtask

    task automatic t_disconnect();
        lock_lost = 1'b1;
        idle(1, "R8");
        ref_tick(1, "R8");
        write_cfg(1, 1, 1);
        idle(1, "R8");
        m_block = 1;
        ref_tick(1, "R8");
        ref_tick(1, "R8");
        @(negedge clk);
        lock_lost = 1'b0;
        @(posedge clk);
        m_block = 0;
        ref_tick(1, "R8");
        write_cfg(1, 1, 0);
    endtask

    task automatic t_exit();
        write_cfg(0, 1, 0);
        chk("R3", "byp_active right after write", byp_active, 1);
        idle(1, "R3");
        chk("R3", "byp_active cleared", byp_active, 0);
        m_byp = 0;
        pulses = 0;
        for (int i = 0; i < 4; i++) ref_tick(1, "R3");
        chk("R3", "no pulses outside mode", pulses, 0);
        write_cfg(1, 1, 0);
        idle(1, "R2");
        chk("R2", "re-entry", byp_active, 1);
        m_byp = 1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_entry();
        t_divide();
        t_reject();
        t_source();
        t_disconnect();
        t_exit();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule